// File: doc/BRIEF.md
# Buffer Pool Allocator

The block hands out and takes back fixed-size buffers from one contiguous memory region. The region starts at a configured base address and holds a configured number of buffers. Every buffer is 2^N bytes, where N is a configured log2 size. Software or another engine talks to the block through a small register port. Reading the buffer register allocates: it pops the address of a free buffer, or returns zero when none is left. Writing an address to the same register frees that buffer and returns it to the pool.

Free buffers are kept as indices in a first-in first-out list. The list starts in ascending address order, and each returned buffer joins the tail. A bitmap records which buffers are currently handed out. Frees that do not name a buffer the pool gave out are dropped and raise a sticky error flag. Two live counters report the buffers in use and the buffers remaining.

The base, count and size inputs must only change while the block is disabled. The configured base should be non-zero so that an address of zero stays reserved for "pool empty".

Top module: `buf_pool_alloc`

## Requirements
- R1: Writing select 0 with bit 0 set, while disabled, enables the pool. It loads every buffer 0..count-1 into the free list, sets the used counter to 0 and the remaining counter to count, and clears the error flag. A configured count above MAX_BUFS is treated as MAX_BUFS.
- R2: A read of select 1 while enabled, with at least one buffer free, returns base + (index << size) for the index at the head of the free list and removes that index. After an enable, indices come out in ascending order.
- R3: A read of select 1 while enabled with no free buffer returns 0 and leaves both counters unchanged.
- R4: Every non-zero allocated address is a multiple of 2^size above base and is below base + count * 2^size.
- R5: No buffer index is handed out again until it has been freed.
- R6: While enabled, used + remaining always equals count. Each successful allocation raises used by 1. Each accepted free lowers used by 1.
- R7: A free is accepted when the written address is aligned, in range and currently allocated. The accepted buffer joins the tail of the free list and is allocated again after all buffers already in the list.
- R8: A free of an address that is below base, misaligned, at or beyond the pool end, or not currently allocated is ignored. It leaves both counters unchanged and sets err_o, which stays set until the next enable.
- R9: While disabled, reads of select 1 return 0 and writes to select 1 change neither the counters nor err_o.
- R10: Every read request gives rsp_valid high with rsp_rdata on the cycle after the request. The read data by select is:
  - 0: {err in bit 1, enable in bit 0}
  - 1: allocated address
  - 2: used count
  - 3: remaining count

  Counter reads show the values before the request's own effect. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Pool base address |
| cfg_count | input | CNT_W | Number of buffers in the pool |
| cfg_size_log2 | input | SZ_W | log2 of the buffer size in bytes |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select |
| req_wdata | input | ADDR_W | Write data (control bits or buffer address) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | ADDR_W | Read data |
| err_o | output | 1 | Sticky bad-free flag |

## Verification
The bench builds the block with MAX_BUFS = 8 and a 32-bit address. This keeps the free list short, so random traffic empties it, fills it and wraps its pointers many times. The first run uses 6 buffers of 64 bytes, so the list never uses its full storage. After a disable, the bench switches to 8 buffers of 16 bytes, which fills the storage exactly and moves alignment to a different bit. Bad frees one byte off alignment, one slot past the end, one slot below base and repeated on the same buffer are all mixed into the random stream.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BUF  = 2'd1,
      SEL_USED = 2'd2,
      SEL_LEFT = 2'd3
   } bpa_sel_e;
endpackage

// File: rtl/bpa_idx_fifo.sv
module bpa_idx_fifo #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic [LVL_W-1:0] init_count,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop,
   output logic [IDX_W-1:0] head_idx,
   output logic [LVL_W-1:0] level
);
   logic [IDX_W-1:0] slots [DEPTH];
   logic [IDX_W-1:0] rd_ptr, wr_ptr;

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
      return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign head_idx = slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      end else if (init) begin
         rd_ptr <= '0;
         wr_ptr <= (init_count >= LVL_W'(DEPTH)) ? '0 : init_count[IDX_W-1:0];
         level  <= init_count;
         for (int i = 0; i < DEPTH; i++) slots[i] <= IDX_W'(i);
      end else begin
         if (push) begin
            slots[wr_ptr] <= push_idx;
            wr_ptr        <= step(wr_ptr);
         end
         if (pop) rd_ptr <= step(rd_ptr);
         if (push && !pop)      level <= level + 1'b1;
         else if (pop && !push) level <= level - 1'b1;
      end
   end

   // R7
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> level < LVL_W'(DEPTH));
   // R3
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> level != '0);
endmodule

// File: rtl/bpa_owner_map.sv
module bpa_owner_map #(
   parameter int NBUF = 16,
   localparam int IDX_W = $clog2(NBUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [IDX_W-1:0] take_idx,
   input  logic             give,
   input  logic [IDX_W-1:0] give_idx,
   output logic [NBUF-1:0]  owned
);
   for (genvar g = 0; g < NBUF; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 owned[g] <= 1'b0;
         else if (clear)                             owned[g] <= 1'b0;
         else if (take && take_idx == IDX_W'(g))     owned[g] <= 1'b1;
         else if (give && give_idx == IDX_W'(g))     owned[g] <= 1'b0;
      end
   end

   // R5
   no_double_handout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !owned[take_idx]);
   // R7
   give_only_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> owned[give_idx]);
endmodule

// File: rtl/bpa_addr_decode.sv
module bpa_addr_decode #(
   parameter int ADDR_W = 32,
   parameter int SZ_W   = 5,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic [CNT_W-1:0]  count,
   output logic [IDX_W-1:0]  idx,
   output logic              shape_ok
);
   logic [ADDR_W-1:0] offset, low_mask, slot;

   always_comb begin
      offset   = addr - base;
      low_mask = ~({ADDR_W{1'b1}} << size_log2);
      slot     = offset >> size_log2;
      shape_ok = (addr >= base) && ((offset & low_mask) == '0)
                 && (slot < ADDR_W'(count));
      idx      = slot[IDX_W-1:0];
   end
endmodule

// File: rtl/buf_pool_alloc.sv
module buf_pool_alloc
   import bpa_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MAX_BUFS = 16,
   parameter int SZ_W     = 5,
   localparam int IDX_W   = $clog2(MAX_BUFS),
   localparam int CNT_W   = $clog2(MAX_BUFS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [SZ_W-1:0]   cfg_size_log2,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_sel,
   input  logic [ADDR_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_rdata,
   output logic              err_o
);
   if (MAX_BUFS < 2) begin : g_bad_depth
      $error("MAX_BUFS must be at least 2");
   end
   if (ADDR_W <= IDX_W + 1) begin : g_bad_width
      $error("ADDR_W too narrow for MAX_BUFS");
   end

   logic              en_q, err_q;
   logic [CNT_W-1:0]  used_q, level, count_eff;
   logic [IDX_W-1:0]  head_idx, free_idx;
   logic [MAX_BUFS-1:0] owned;
   logic              shape_ok;
   logic              ctrl_wr, init, alloc_rd, pop, free_wr, good_free, bad_free;
   logic [ADDR_W-1:0] alloc_addr, size_mask;
   bpa_sel_e          sel;

   assign sel       = bpa_sel_e'(req_sel);
   assign count_eff = (cfg_count > CNT_W'(MAX_BUFS)) ? CNT_W'(MAX_BUFS) : cfg_count;
   assign ctrl_wr   = req_valid && req_write && sel == SEL_CTRL;
   assign init      = ctrl_wr && req_wdata[0] && !en_q;
   assign alloc_rd  = req_valid && !req_write && sel == SEL_BUF;
   assign pop       = alloc_rd && en_q && level != '0;
   assign free_wr   = req_valid && req_write && sel == SEL_BUF && en_q;
   assign good_free = free_wr && shape_ok && owned[free_idx];
   assign bad_free  = free_wr && !good_free;
   assign alloc_addr = cfg_base + (ADDR_W'(head_idx) << cfg_size_log2);
   assign size_mask  = ~({ADDR_W{1'b1}} << cfg_size_log2);

   bpa_addr_decode #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) decode_i (
      .addr(req_wdata), .base(cfg_base), .size_log2(cfg_size_log2), .count(count_eff),
      .idx(free_idx), .shape_ok(shape_ok));

   bpa_idx_fifo #(.DEPTH(MAX_BUFS)) fifo_i (
      .clk(clk), .rst_n(rst_n), .init(init), .init_count(count_eff),
      .push(good_free), .push_idx(free_idx), .pop(pop),
      .head_idx(head_idx), .level(level));

   bpa_owner_map #(.NBUF(MAX_BUFS)) owner_i (
      .clk(clk), .rst_n(rst_n), .clear(init),
      .take(pop), .take_idx(head_idx), .give(good_free), .give_idx(free_idx),
      .owned(owned));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         err_q  <= 1'b0;
         used_q <= '0;
      end else begin
         if (ctrl_wr) en_q <= req_wdata[0];
         if (init)          err_q <= 1'b0;
         else if (bad_free) err_q <= 1'b1;
         if (init)           used_q <= '0;
         else if (pop)       used_q <= used_q + 1'b1;
         else if (good_free) used_q <= used_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         if (req_valid && !req_write) begin
            unique case (sel)
               SEL_CTRL: rsp_rdata <= ADDR_W'({err_q, en_q});
               SEL_BUF:  rsp_rdata <= pop ? alloc_addr : '0;
               SEL_USED: rsp_rdata <= ADDR_W'(used_q);
               SEL_LEFT: rsp_rdata <= ADDR_W'(level);
            endcase
         end
      end
   end

   assign err_o = err_q;

   // R6
   count_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> ({1'b0, used_q} + {1'b0, level}) == {1'b0, count_eff});
   // R3
   empty_returns_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_rd && (!en_q || level == '0)) |=> rsp_valid && rsp_rdata == '0);
   // R4
   alloc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> rsp_rdata >= cfg_base && ((rsp_rdata - cfg_base) & size_mask) == '0);
   // R8
   bad_free_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_free |=> $stable(used_q) && err_o);
   // R9
   disabled_free_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && sel == SEL_BUF && !en_q) |=> $stable(used_q) && $stable(level) && $stable(err_o));
endmodule

// File: tb/buf_pool_alloc_tb.sv
module buf_pool_alloc_tb_top;
   localparam int PERIOD = 10;
   localparam int AW = 32;
   localparam int NB = 8;
   localparam int CW = $clog2(NB + 1);

   logic clk = 0, rst_n = 0;
   logic [AW-1:0] cfg_base;
   logic [CW-1:0] cfg_count;
   logic [4:0]    cfg_size;
   logic req_valid = 0, req_write = 0;
   logic [1:0] req_sel = 0;
   logic [AW-1:0] req_wdata = 0;
   logic rsp_valid, err_o;
   logic [AW-1:0] rsp_rdata;

   int vectors = 0, misses = 0;
   bit done = 0;

   // model state
   int q[$];
   bit own[NB];
   int used;
   bit m_en, m_err;

   always #(PERIOD/2) clk = ~clk;

   buf_pool_alloc #(.ADDR_W(AW), .MAX_BUFS(NB), .SZ_W(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_count(cfg_count),
      .cfg_size_log2(cfg_size), .req_valid(req_valid), .req_write(req_write),
      .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .err_o(err_o));

   function automatic logic [AW-1:0] addr_of(int idx);
      return cfg_base + (AW'(idx) << cfg_size);
   endfunction

   function automatic bit free_ok(logic [AW-1:0] a);
      logic [AW-1:0] off;
      if (a < cfg_base) return 0;
      off = a - cfg_base;
      if ((off & ((AW'(1) << cfg_size) - 1)) != 0) return 0;
      if ((off >> cfg_size) >= AW'(cfg_count)) return 0;
      return own[int'(off >> cfg_size)];
   endfunction

   task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(bit wr, logic [1:0] sel, logic [AW-1:0] wd, output logic [AW-1:0] rd, output logic vld);
      req_valid = 1; req_write = wr; req_sel = sel; req_wdata = wd;
      @(negedge clk);
      req_valid = 0; req_write = 0;
      rd = rsp_rdata; vld = rsp_valid;
   endtask

   task automatic do_read(logic [1:0] sel, logic [AW-1:0] exp, string req);
      logic [AW-1:0] rd; logic vld;
      access(0, sel, '0, rd, vld);
      chk(vld === 1'b1, "R10", AW'(vld), 1);
      chk(rd === exp, req, rd, exp);
   endtask

   task automatic do_enable(bit on);
      logic [AW-1:0] rd; logic vld;
      access(1, 2'd0, AW'(on), rd, vld);
      if (on && !m_en) begin
         q.delete();
         for (int i = 0; i < int'(cfg_count); i++) begin q.push_back(i); own[i] = 0; end
         used = 0; m_err = 0;
      end
      m_en = on;
   endtask

   task automatic do_alloc(string req);
      logic [AW-1:0] rd, exp; logic vld;
      int idx;
      exp = '0; idx = -1;
      if (m_en && q.size() > 0) begin
         idx = q.pop_front(); own[idx] = 1; used++; exp = addr_of(idx);
      end
      access(0, 2'd1, '0, rd, vld);
      chk(vld === 1'b1, "R10", AW'(vld), 1);
      chk(rd === exp, req, rd, exp);
      if (idx >= 0) begin
         // R4: aligned and within the pool
         chk(rd >= cfg_base && ((rd - cfg_base) & ((AW'(1) << cfg_size) - 1)) == 0
             && rd < cfg_base + (AW'(cfg_count) << cfg_size), "R4", rd, exp);
      end
   endtask

   task automatic do_free(logic [AW-1:0] a, string req);
      logic [AW-1:0] rd; logic vld;
      if (m_en) begin
         if (free_ok(a)) begin
            int idx = int'((a - cfg_base) >> cfg_size);
            own[idx] = 0; used--; q.push_back(idx);
         end else m_err = 1;
      end
      access(1, 2'd1, a, rd, vld);
      chk(err_o === m_err, req, AW'(err_o), AW'(m_err));
   endtask

   task automatic check_counts(string req);
      do_read(2'd2, AW'(used), req);
      do_read(2'd3, AW'(q.size()), req);
   endtask

   task automatic random_phase(int n);
      for (int k = 0; k < n; k++) begin
         int r = int'($urandom_range(99));
         if (r < 40) do_alloc("R2");
         else if (r < 70) begin
            int pick = int'($urandom_range(NB - 1));
            if (pick < int'(cfg_count) && own[pick]) do_free(addr_of(pick), "R7");
            else do_alloc("R2");
         end else if (r < 80) begin
            int kind = int'($urandom_range(3));
            int pick = int'($urandom_range(int'(cfg_count) - 1));
            case (kind)
               0: do_free(addr_of(pick) + 1, "R8");
               1: do_free(addr_of(int'(cfg_count)), "R8");
               2: do_free(cfg_base - (AW'(1) << cfg_size), "R8");
               default: if (!own[pick]) do_free(addr_of(pick), "R8");
                        else do_free(addr_of(pick) + 2, "R8");
            endcase
         end else check_counts("R6");
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      misses++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h0000_5EED);
      cfg_base = 32'h0001_0000; cfg_count = CW'(6); cfg_size = 5'd6;
      m_en = 0; m_err = 0; used = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(rsp_valid === 1'b0, "R10", AW'(rsp_valid), 0);
      chk(err_o === 1'b0, "R8", AW'(err_o), 0);
      do_read(2'd0, 0, "R10");
      // R9: disabled allocate and free
      do_alloc("R9");
      do_free(addr_of(0), "R9");
      do_read(2'd2, 0, "R9");
      // R1: enable fills the pool
      do_enable(1);
      do_read(2'd0, 1, "R1");
      check_counts("R1");
      // R2: ascending handout, R6 counters
      for (int i = 0; i < 6; i++) do_alloc("R2");
      check_counts("R6");
      // R3: exhausted
      do_alloc("R3");
      check_counts("R3");
      // R7: freed buffers come back in free order
      do_free(addr_of(3), "R7");
      do_free(addr_of(1), "R7");
      check_counts("R7");
      do_alloc("R7");
      do_alloc("R7");
      // R8: bad frees
      do_free(addr_of(2), "R7");
      do_free(addr_of(2), "R8");
      do_free(addr_of(4) + 4, "R8");
      do_free(addr_of(6), "R8");
      do_free(cfg_base - 64, "R8");
      check_counts("R8");
      do_read(2'd0, 3, "R8");
      // R9: disabled state is frozen, then re-enable clears error
      do_enable(0);
      do_free(addr_of(0), "R9");
      do_alloc("R9");
      check_counts("R9");
      do_enable(1);
      do_read(2'd0, 1, "R1");
      check_counts("R1");
      random_phase(500);
      // second configuration fills the whole list storage
      do_enable(0);
      cfg_count = CW'(8); cfg_size = 5'd4;
      do_enable(1);
      check_counts("R1");
      for (int i = 0; i < 9; i++) do_alloc("R3");
      check_counts("R3");
      random_phase(600);
      finish_run();
   end
endmodule